// File: doc/BRIEF.md
# Flash Access Mode Controller

This block sits between a CPU, a debug port and an on-chip flash made of a 64 KB data array plus a 128-byte information array. One 8-bit configuration register on a small register bus selects a one-hot operating mode and an overlay map. The mode decides what an ordinary CPU write to the flash space means: nothing, a byte program, an erase of the 512-byte sector that holds the address, or an erase of the whole flash. Each such write becomes a one-cycle command on the array interface. The overlay map can place the information array over the top 128 bytes of the address space for both reads and programs.

CPU reads finish in the same cycle in every mode except program mode. In program mode the ready signal stays low for two wait cycles. Right after reset the block reads the last byte of the information array through its read port. If that byte matches a signature value, the block locks. While locked, program and sector-erase writes are dropped and recorded in a sticky violation flag, and debug reads return zero with an error strobe. A completed full erase is the only thing that removes the lock.

Flash cell timing and erase sequencing belong to the array side. The array reports the end of each command with a done pulse.

Top module: `flash_mode_ctrl`

## Requirements
- R1: After reset, and once the one boot cycle has passed, the configuration register at register address 0x96 reads 0x01 (unlocked). Any other register address reads 0x00. While reset or the boot cycle is in progress, `cpu_ready` is 0.
- R2: A register write to 0x96 loads bit 5 (map select) and bits 4:0 (mode). Bit 6 always reads 0. Bit 7 reads the lock flag and cannot be written.
- R3: A written mode value other than 0x01 (read-only), 0x04 (program), 0x08 (sector erase) or 0x10 (full erase) leaves the mode unchanged. Map select still takes bit 5.
- R4: With map select 0, every CPU address goes to the data array unchanged (`arr_rd_info`=0). With map select 1, addresses 0xFF80..0xFFFF go to the information array (`arr_rd_info`=1, address = offset 0..127).
- R5: Outside program mode, a CPU read has `cpu_ready`=1 and valid data in the same cycle. In program mode, `cpu_ready` is 0 for the first two cycles of a held read and 1, with valid data, in the third.
- R6: In program mode, a CPU write produces, one cycle later, a single-cycle `arr_cmd_valid` with op 1. It carries the steered address, the information flag and the write data.
- R7: In sector-erase mode, a CPU write produces, one cycle later, a command with op 2 and address {addr[15:9], 9'b0}, targeting the data array.
- R8: In full-erase mode, a CPU write produces, one cycle later, a command with op 3 and address 0.
- R9: In read-only mode, CPU writes produce no command.
- R10: If the last information byte read during the boot cycle equals 0x55, the lock flag (register bit 7) is set.
- R11: While locked, program and sector-erase writes produce no command and set `viol_sticky`, which stays set until reset.
- R12: A debug read gives its result one cycle later. Unlocked, the result is the array byte and `dbg_err` is 0. Locked, the result is 0x00 and `dbg_err` is high for exactly that one cycle.
- R13: A full-erase write is issued even while locked. The `arr_done` that follows it clears the lock flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| cpu_rd | input | 1 | CPU flash read, held until ready |
| cpu_we | input | 1 | CPU flash write, one cycle |
| cpu_addr | input | 16 | CPU flash address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data |
| cpu_ready | output | 1 | Read complete |
| dbg_rd | input | 1 | Debug read request |
| dbg_addr | input | 16 | Debug read address |
| dbg_rdata | output | 8 | Debug read result, one cycle after request |
| dbg_err | output | 1 | Debug read refused |
| arr_rd_addr | output | 16 | Array read address (CPU/boot port) |
| arr_rd_info | output | 1 | Read port targets information array |
| arr_rd_data | input | 8 | Array read data (CPU/boot port) |
| arr_dbg_addr | output | 16 | Array read address (debug port) |
| arr_dbg_info | output | 1 | Debug port targets information array |
| arr_dbg_data | input | 8 | Array read data (debug port) |
| arr_cmd_valid | output | 1 | Command strobe |
| arr_cmd_op | output | 2 | 1 program, 2 sector erase, 3 full erase |
| arr_cmd_addr | output | 16 | Command address |
| arr_cmd_info | output | 1 | Command targets information array |
| arr_cmd_data | output | 8 | Program data |
| arr_done | input | 1 | Array finished the last command |
| viol_sticky | output | 1 | A locked program/erase write was dropped |

## Verification
A table of read vectors runs addresses on both sides of 0xFF80, at both ends of the space, under both map settings. This separates a correct overlay from one with an off-by-one window edge and from one that ignores map select. Writes are then repeated under each mode, so every command op and address form is seen once, along with the silent read-only case. A second reset with the signature planted in the information array repeats the program, sector-erase and debug patterns. Those runs show that only the lock changes the outcome, and that a full erase releases it.

// File: rtl/fmc_pkg.sv
package fmc_pkg;
  localparam int DW = 8;

  localparam logic [4:0] MODE_READ = 5'b00001;
  localparam logic [4:0] MODE_PROG = 5'b00100;
  localparam logic [4:0] MODE_SECT = 5'b01000;
  localparam logic [4:0] MODE_MASS = 5'b10000;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PROG = 2'd1,
    OP_SECT = 2'd2,
    OP_MASS = 2'd3
  } op_e;

  function automatic logic mode_ok(input logic [4:0] m);
    return (m == MODE_READ) || (m == MODE_PROG) ||
           (m == MODE_SECT) || (m == MODE_MASS);
  endfunction
endpackage

// File: rtl/fmc_cfg_reg.sv
module fmc_cfg_reg
  import fmc_pkg::*;
#(
  parameter int RA_W = 8,
  parameter logic [RA_W-1:0] CFG_ADDR = 8'h96
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [RA_W-1:0] reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  input  logic            secure,
  output logic [DW-1:0]   reg_rdata,
  output logic            map_sel,
  output logic [4:0]      mode
);
  logic       hit;
  logic       map_d, map_q;
  logic [4:0] mode_d, mode_q;

  assign hit = (reg_addr == CFG_ADDR);

  always_comb begin
    map_d  = map_q;
    mode_d = mode_q;
    if (reg_wr && hit) begin
      map_d = reg_wdata[5];
      if (mode_ok(reg_wdata[4:0])) mode_d = reg_wdata[4:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q  <= 1'b0;
      mode_q <= MODE_READ;
    end else begin
      map_q  <= map_d;
      mode_q <= mode_d;
    end
  end

  assign reg_rdata = hit ? {secure, 1'b0, map_q, mode_q} : '0;
  assign map_sel   = map_q;
  assign mode      = mode_q;
endmodule

// File: rtl/fmc_steer.sv
module fmc_steer #(
  parameter int ADDR_W     = 16,
  parameter int INFO_BYTES = 128
) (
  input  logic              map_sel,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic              info_sel
);
  localparam int IW = $clog2(INFO_BYTES);
  localparam logic [ADDR_W-1:0] INFO_BASE = ADDR_W'((2 ** ADDR_W) - INFO_BYTES);

  assign info_sel = map_sel && (addr_in >= INFO_BASE);
  assign addr_out = info_sel ? ADDR_W'(addr_in[IW-1:0]) : addr_in;
endmodule

// File: rtl/fmc_rd_wait.sv
module fmc_rd_wait #(
  parameter int WAIT_STATES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd,
  input  logic prog,
  output logic ready
);
  generate
    if (WAIT_STATES == 0) begin : g_nowait
      assign ready = 1'b1;
    end else begin : g_wait
      localparam int CNT_W = $clog2(WAIT_STATES + 1);
      localparam logic [CNT_W-1:0] WAIT_C = CNT_W'(WAIT_STATES);
      logic [CNT_W-1:0] cnt_d, cnt_q;
      logic             done;

      assign done = (cnt_q == WAIT_C);

      always_comb begin
        cnt_d = cnt_q;
        if (!rd || !prog || done) cnt_d = '0;
        else                      cnt_d = cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign ready = !prog || done;
    end
  endgenerate
endmodule

// File: rtl/fmc_cmd_gen.sv
module fmc_cmd_gen
  import fmc_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int SECTOR_BYTES = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [ADDR_W-1:0] steer_addr,
  input  logic              steer_info,
  input  logic [DW-1:0]     wdata,
  input  logic [4:0]        mode,
  input  logic              secure,
  output logic              cmd_valid,
  output logic [1:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_info,
  output logic [DW-1:0]     cmd_data,
  output logic              viol
);
  localparam int SB = $clog2(SECTOR_BYTES);

  op_e               op_sel;
  logic              blocked, issue;
  logic              valid_q, viol_d, viol_q, info_d, info_q;
  logic [1:0]        op_q;
  logic [ADDR_W-1:0] addr_d, addr_q;
  logic [DW-1:0]     data_q;

  always_comb begin
    case (mode)
      MODE_PROG: op_sel = OP_PROG;
      MODE_SECT: op_sel = OP_SECT;
      MODE_MASS: op_sel = OP_MASS;
      default:   op_sel = OP_NONE;
    endcase
    blocked = secure && ((op_sel == OP_PROG) || (op_sel == OP_SECT));
    issue   = en && we && (op_sel != OP_NONE) && !blocked;
    viol_d  = viol_q || (en && we && blocked);
    info_d  = 1'b0;
    addr_d  = '0;
    if (op_sel == OP_PROG) begin
      addr_d = steer_addr;
      info_d = steer_info;
    end else if (op_sel == OP_SECT) begin
      addr_d = {cpu_addr[ADDR_W-1:SB], {SB{1'b0}}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      viol_q  <= 1'b0;
      op_q    <= OP_NONE;
      addr_q  <= '0;
      info_q  <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= issue;
      viol_q  <= viol_d;
      if (issue) begin
        op_q   <= op_sel;
        addr_q <= addr_d;
        info_q <= info_d;
        data_q <= wdata;
      end
    end
  end

  assign cmd_valid = valid_q;
  assign cmd_op    = op_q;
  assign cmd_addr  = addr_q;
  assign cmd_info  = info_q;
  assign cmd_data  = data_q;
  assign viol      = viol_q;
endmodule

// File: rtl/flash_mode_ctrl.sv
module flash_mode_ctrl
  import fmc_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int RA_W         = 8,
  parameter logic [RA_W-1:0] CFG_ADDR = 8'h96,
  parameter int INFO_BYTES   = 128,
  parameter int SECTOR_BYTES = 512,
  parameter int WAIT_STATES  = 2,
  parameter logic [7:0] SIG_BYTE = 8'h55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              cpu_rd,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  output logic              cpu_ready,
  input  logic              dbg_rd,
  input  logic [ADDR_W-1:0] dbg_addr,
  output logic [7:0]        dbg_rdata,
  output logic              dbg_err,
  output logic [ADDR_W-1:0] arr_rd_addr,
  output logic              arr_rd_info,
  input  logic [7:0]        arr_rd_data,
  output logic [ADDR_W-1:0] arr_dbg_addr,
  output logic              arr_dbg_info,
  input  logic [7:0]        arr_dbg_data,
  output logic              arr_cmd_valid,
  output logic [1:0]        arr_cmd_op,
  output logic [ADDR_W-1:0] arr_cmd_addr,
  output logic              arr_cmd_info,
  output logic [7:0]        arr_cmd_data,
  input  logic              arr_done,
  output logic              viol_sticky
);
  localparam logic [ADDR_W-1:0] SIG_LOC = ADDR_W'(INFO_BYTES - 1);

  logic              rst_meta, rst_sync_n;
  logic              boot_done_d, boot_done_q;
  logic              secure_d, secure_q;
  logic              mass_pend_d, mass_pend_q;
  logic              dbg_err_d, dbg_err_q;
  logic [7:0]        dbg_data_d, dbg_data_q;
  logic              map_sel;
  logic [4:0]        mode_w;
  logic [ADDR_W-1:0] cpu_steer_addr;
  logic              cpu_steer_info;
  logic              wait_ready;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  fmc_cfg_reg #(.RA_W(RA_W), .CFG_ADDR(CFG_ADDR)) u_cfg (
    .clk(clk), .rst_n(rst_sync_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .secure(secure_q), .reg_rdata(reg_rdata),
    .map_sel(map_sel), .mode(mode_w)
  );

  fmc_steer #(.ADDR_W(ADDR_W), .INFO_BYTES(INFO_BYTES)) u_steer_cpu (
    .map_sel(map_sel), .addr_in(cpu_addr),
    .addr_out(cpu_steer_addr), .info_sel(cpu_steer_info)
  );

  fmc_steer #(.ADDR_W(ADDR_W), .INFO_BYTES(INFO_BYTES)) u_steer_dbg (
    .map_sel(map_sel), .addr_in(dbg_addr),
    .addr_out(arr_dbg_addr), .info_sel(arr_dbg_info)
  );

  fmc_rd_wait #(.WAIT_STATES(WAIT_STATES)) u_wait (
    .clk(clk), .rst_n(rst_sync_n), .rd(cpu_rd),
    .prog(mode_w == MODE_PROG), .ready(wait_ready)
  );

  fmc_cmd_gen #(.ADDR_W(ADDR_W), .SECTOR_BYTES(SECTOR_BYTES)) u_cmd (
    .clk(clk), .rst_n(rst_sync_n), .en(boot_done_q), .we(cpu_we),
    .cpu_addr(cpu_addr), .steer_addr(cpu_steer_addr),
    .steer_info(cpu_steer_info), .wdata(cpu_wdata), .mode(mode_w),
    .secure(secure_q), .cmd_valid(arr_cmd_valid), .cmd_op(arr_cmd_op),
    .cmd_addr(arr_cmd_addr), .cmd_info(arr_cmd_info),
    .cmd_data(arr_cmd_data), .viol(viol_sticky)
  );

  // boot cycle borrows the read port to fetch the signature byte
  assign arr_rd_addr = boot_done_q ? cpu_steer_addr : SIG_LOC;
  assign arr_rd_info = boot_done_q ? cpu_steer_info : 1'b1;
  assign cpu_rdata   = arr_rd_data;
  assign cpu_ready   = boot_done_q && wait_ready;

  always_comb begin
    boot_done_d = 1'b1;
    secure_d    = secure_q;
    mass_pend_d = mass_pend_q;
    if (!boot_done_q) begin
      secure_d = (arr_rd_data == SIG_BYTE);
    end else if (arr_done && mass_pend_q) begin
      secure_d = 1'b0;
    end
    if (arr_cmd_valid && (arr_cmd_op == OP_MASS)) mass_pend_d = 1'b1;
    else if (arr_done)                            mass_pend_d = 1'b0;
    dbg_err_d  = dbg_rd && (secure_q || !boot_done_q);
    dbg_data_d = dbg_err_d ? 8'h00 : arr_dbg_data;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      boot_done_q <= 1'b0;
      secure_q    <= 1'b0;
      mass_pend_q <= 1'b0;
      dbg_err_q   <= 1'b0;
      dbg_data_q  <= '0;
    end else begin
      boot_done_q <= boot_done_d;
      secure_q    <= secure_d;
      mass_pend_q <= mass_pend_d;
      dbg_err_q   <= dbg_err_d;
      if (dbg_rd) dbg_data_q <= dbg_data_d;
    end
  end

  assign dbg_rdata = dbg_data_q;
  assign dbg_err   = dbg_err_q;
endmodule

// File: rtl/fmc_chk.sv
module fmc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       boot_done,
  input logic       secure,
  input logic       mass_pend,
  input logic [4:0] mode,
  input logic       cpu_rd,
  input logic       cpu_we,
  input logic       cpu_ready,
  input logic       dbg_err,
  input logic [7:0] dbg_rdata,
  input logic       arr_cmd_valid,
  input logic [1:0] arr_cmd_op,
  input logic       arr_done
);
  // R3
  mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 5'b00001) || (mode == 5'b00100) || (mode == 5'b01000) || (mode == 5'b10000));

  // R5
  prog_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 5'b00100 && cpu_rd && !$past(cpu_rd)) |-> !cpu_ready);

  // R6
  prog_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_done && cpu_we && mode == 5'b00100 && !secure) |=> (arr_cmd_valid && arr_cmd_op == 2'd1));

  // R9
  read_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && mode == 5'b00001) |=> !arr_cmd_valid);

  // R11
  locked_only_mass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_cmd_valid && secure) |-> (arr_cmd_op == 2'd3));

  // R12
  refused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_err |-> (dbg_rdata == 8'h00));

  // R13
  unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_done && arr_done && mass_pend) |=> !secure);
endmodule

bind flash_mode_ctrl fmc_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .boot_done(boot_done_q), .secure(secure_q),
  .mass_pend(mass_pend_q), .mode(mode_w), .cpu_rd(cpu_rd), .cpu_we(cpu_we),
  .cpu_ready(cpu_ready), .dbg_err(dbg_err), .dbg_rdata(dbg_rdata),
  .arr_cmd_valid(arr_cmd_valid), .arr_cmd_op(arr_cmd_op), .arr_done(arr_done)
);

// File: tb/sim_flash_mode_ctrl.sv
module sim_flash_mode_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h00, reg_wdata = 8'h00, reg_rdata;
  logic        cpu_rd = 1'b0, cpu_we = 1'b0, cpu_ready;
  logic [15:0] cpu_addr = 16'h0;
  logic [7:0]  cpu_wdata = 8'h00, cpu_rdata;
  logic        dbg_rd = 1'b0, dbg_err;
  logic [15:0] dbg_addr = 16'h0;
  logic [7:0]  dbg_rdata;
  logic [15:0] arr_rd_addr, arr_dbg_addr, arr_cmd_addr;
  logic        arr_rd_info, arr_dbg_info, arr_cmd_valid, arr_cmd_info, viol_sticky;
  logic [7:0]  arr_rd_data, arr_dbg_data, arr_cmd_data;
  logic [1:0]  arr_cmd_op;
  logic        arr_done = 1'b0;
  logic        erased = 1'b0;
  logic [7:0]  sig = 8'h43;

  int vectors = 0;
  int fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  flash_mode_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_rd(cpu_rd),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready), .dbg_rd(dbg_rd),
    .dbg_addr(dbg_addr), .dbg_rdata(dbg_rdata), .dbg_err(dbg_err),
    .arr_rd_addr(arr_rd_addr), .arr_rd_info(arr_rd_info),
    .arr_rd_data(arr_rd_data), .arr_dbg_addr(arr_dbg_addr),
    .arr_dbg_info(arr_dbg_info), .arr_dbg_data(arr_dbg_data),
    .arr_cmd_valid(arr_cmd_valid), .arr_cmd_op(arr_cmd_op),
    .arr_cmd_addr(arr_cmd_addr), .arr_cmd_info(arr_cmd_info),
    .arr_cmd_data(arr_cmd_data), .arr_done(arr_done),
    .viol_sticky(viol_sticky)
  );

  // array model: data byte = hi ^ lo, info byte i = i ^ 0x3C, last info byte = sig
  function automatic logic [7:0] model_byte(input logic info, input logic [15:0] a);
    if (erased) return 8'hFF;
    if (!info) return a[7:0] ^ a[15:8];
    if (a[6:0] == 7'h7F) return sig;
    return {1'b0, a[6:0]} ^ 8'h3C;
  endfunction

  assign arr_rd_data  = model_byte(arr_rd_info, arr_rd_addr);
  assign arr_dbg_data = model_byte(arr_dbg_info, arr_dbg_addr);

  always @(posedge clk) begin
    arr_done <= arr_cmd_valid;
    if (arr_cmd_valid && arr_cmd_op == 2'd3) erased <= 1'b1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1 chk(cpu_ready == 1'b0, "R1 ready low in reset", 32'(cpu_ready), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic reg_write(input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'h96; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_check(input logic [7:0] a, input logic [7:0] exp, input string req);
    reg_addr = a;
    #1 chk(reg_rdata == exp, req, 32'(reg_rdata), 32'(exp));
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_we = 1'b0;
    #1;
  endtask

  task automatic cmd_check(input logic [1:0] op, input logic [15:0] a, input logic info,
                           input logic [7:0] d, input string req);
    chk(arr_cmd_valid && arr_cmd_op == op && arr_cmd_addr == a && arr_cmd_info == info &&
        (op != 2'd1 || arr_cmd_data == d), req,
        {5'd0, arr_cmd_valid, arr_cmd_op, arr_cmd_addr, arr_cmd_data},
        {5'd0, 1'b1, op, a, d});
    @(negedge clk);
    #1 chk(arr_cmd_valid == 1'b0, {req, " single cycle"}, 32'(arr_cmd_valid), 0);
  endtask

  task automatic dbg_read(input logic [15:0] a, input logic [7:0] exp, input logic err, input string req);
    @(negedge clk);
    dbg_rd = 1'b1; dbg_addr = a;
    @(negedge clk);
    dbg_rd = 1'b0;
    #1 chk(dbg_rdata == exp && dbg_err == err, req, {dbg_err, dbg_rdata}, {err, exp});
    @(negedge clk);
    #1 chk(dbg_err == 1'b0, {req, " err one cycle"}, 32'(dbg_err), 0);
  endtask

  // {map, addr, expected info flag, expected data}
  localparam logic [25:0] VECS [8] = '{
    {1'b0, 16'h0000, 1'b0, 8'h00},
    {1'b0, 16'h1234, 1'b0, 8'h26},
    {1'b0, 16'hFF80, 1'b0, 8'h7F},
    {1'b0, 16'hFFFF, 1'b0, 8'h00},
    {1'b1, 16'hFF7F, 1'b0, 8'h80},
    {1'b1, 16'hFF80, 1'b1, 8'h3C},
    {1'b1, 16'hFFC5, 1'b1, 8'h79},
    {1'b1, 16'hFFFF, 1'b1, 8'h43}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    reg_check(8'h96, 8'h01, "R1 cfg after reset");
    reg_check(8'h95, 8'h00, "R1 other address");
    chk(cpu_ready == 1'b1, "R1 ready after boot", 32'(cpu_ready), 1);

    // R4 / R5 steering table, read-only mode, zero wait
    for (int i = 0; i < 8; i++) begin
      logic [15:0] exp_addr;
      reg_write({2'b00, VECS[i][25], 5'b00001});
      @(negedge clk);
      cpu_rd = 1'b1; cpu_addr = VECS[i][24:9];
      exp_addr = VECS[i][8] ? {9'd0, VECS[i][15:9]} : VECS[i][24:9];
      #1 chk(arr_rd_info == VECS[i][8] && arr_rd_addr == exp_addr && cpu_rdata == VECS[i][7:0] &&
             cpu_ready, "R4 R5 steered read",
             {7'd0, cpu_ready, arr_rd_info, arr_rd_addr, cpu_rdata},
             {7'd0, 1'b1, VECS[i][8], exp_addr, VECS[i][7:0]});
      cpu_rd = 1'b0;
    end

    // R2 / R3 register fields
    reg_write(8'hFF);
    reg_check(8'h96, 8'h21, "R3 invalid mode kept, map written, R2 bits 7:6");
    reg_write(8'h02);
    reg_check(8'h96, 8'h01, "R3 reserved mode ignored");
    reg_write(8'h04);
    reg_check(8'h96, 8'h04, "R2 program mode written");

    // R5 program-mode wait states
    @(negedge clk);
    cpu_rd = 1'b1; cpu_addr = 16'h0102;
    #1 chk(cpu_ready == 1'b0, "R5 wait 1", 32'(cpu_ready), 0);
    @(negedge clk);
    #1 chk(cpu_ready == 1'b0, "R5 wait 2", 32'(cpu_ready), 0);
    @(negedge clk);
    #1 chk(cpu_ready == 1'b1 && cpu_rdata == 8'h03, "R5 ready third cycle",
           {cpu_ready, cpu_rdata}, {1'b1, 8'h03});
    cpu_rd = 1'b0;

    // R6 program commands
    cpu_write(16'h1234, 8'hA5);
    cmd_check(2'd1, 16'h1234, 1'b0, 8'hA5, "R6 program data array");
    reg_write(8'h24);
    cpu_write(16'hFF90, 8'h5A);
    cmd_check(2'd1, 16'h0010, 1'b1, 8'h5A, "R6 program info overlay");

    // R7 sector erase
    reg_write(8'h08);
    cpu_write(16'h1234, 8'h00);
    cmd_check(2'd2, 16'h1200, 1'b0, 8'h00, "R7 sector erase");

    // R9 read-only mode write
    reg_write(8'h01);
    cpu_write(16'h4000, 8'h77);
    chk(arr_cmd_valid == 1'b0, "R9 no command in read-only", 32'(arr_cmd_valid), 0);
    chk(viol_sticky == 1'b0, "R11 no violation while unlocked", 32'(viol_sticky), 0);

    dbg_read(16'h0055, 8'h55, 1'b0, "R12 unlocked debug read");

    // locked run
    sig = 8'h55;
    do_reset();
    @(negedge clk);
    reg_check(8'h96, 8'h81, "R10 lock from signature");
    dbg_read(16'h0055, 8'h00, 1'b1, "R12 locked debug read");
    reg_write(8'h04);
    cpu_write(16'h2000, 8'h11);
    chk(arr_cmd_valid == 1'b0 && viol_sticky == 1'b1, "R11 locked program dropped",
        {arr_cmd_valid, viol_sticky}, 2'b01);
    reg_write(8'h08);
    cpu_write(16'h2000, 8'h11);
    chk(arr_cmd_valid == 1'b0, "R11 locked sector erase dropped", 32'(arr_cmd_valid), 0);
    repeat (3) @(negedge clk);
    chk(viol_sticky == 1'b1, "R11 violation sticky", 32'(viol_sticky), 1);

    // R8 / R13 full erase unlocks
    reg_write(8'h10);
    cpu_write(16'h8888, 8'h00);
    cmd_check(2'd3, 16'h0000, 1'b0, 8'h00, "R8 R13 full erase issued while locked");
    repeat (2) @(negedge clk);
    reg_check(8'h96, 8'h10, "R13 lock cleared after done");
    dbg_read(16'h0055, 8'hFF, 1'b0, "R13 debug read after unlock");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule